// File: doc/BRIEF.md
# Packed-Pixel Grayscale Converter

This engine walks a region of 16-bit 5-6-5 colour pixels in a word-addressed memory. It handles one pixel at a time. For each pixel it reads the word and rebuilds 8-bit red, green and blue values. It then computes a brightness value and writes a grey pixel, packed with equal channels, to a second region at the same index.

A one-cycle start pulse begins a pass. The brightness mode is sampled from the mode input at that same moment. Mode 0 selects a weighted sum that uses only shifts and adds. Mode 1 selects the plain average of the three channels, which an iterative divider computes by subtracting three repeatedly.

When the final grey word has been stored, the engine raises a completion flag and emits a single-cycle strobe. A host uses the strobe to flush the output region. The memory port is synchronous and returns read data exactly one cycle after the address.

Top module: `gray_pixel_engine`

## Requirements
- R1: While reset is asserted and directly after it, done_o, dump_o and mem_we_o are all 0.
- R2: An input word carries red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Red and blue are widened to 8 bits by appending three zero bits, and green by appending two zero bits.
- R3: In mode 0 the brightness is Y = ((3*R8 + B8) >> 3) + (G8 >> 1), with every shift truncating.
- R4: In mode 1 the brightness is floor((R8 + G8 + B8) / 3).
- R5: Each written word is {Y[7:3], Y[7:2], Y[7:3]}, which places the three grey channel fields in bits 15:11, 10:5 and 4:0.
- R6: Pixel i is read from SRC_BASE+i and its result is written to DST_BASE+i, for i ascending from 0 to PIX_COUNT-1. Each destination word is written once, and no address outside the destination region is written.
- R7: In mode 0, successive writes are exactly 4 clock cycles apart.
- R8: In mode 1, the write of pixel i+1 comes 5 + floor(sum/3) cycles after the write of pixel i, where sum is the channel sum of pixel i+1.
- R9: dump_o is high for exactly one cycle, the cycle after the last write. done_o rises in that same cycle and stays high until the next accepted start.
- R10: A start pulse, with any mode value, that arrives while a pass is running is ignored. The pass continues in its original mode and writes each pixel once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a pass when the engine is idle |
| avg_mode_i | input | 1 | Brightness mode sampled at start: 0 weighted, 1 average |
| mem_addr_o | output | ADDR_W | Word address for a read or a write |
| mem_rdata_i | input | PIX_W | Read data, valid one cycle after the address |
| mem_wdata_o | output | PIX_W | Packed grey word to write |
| mem_we_o | output | 1 | Write enable |
| done_o | output | 1 | Pass complete; held until the next start |
| dump_o | output | 1 | Single-cycle strobe after the final write |

## Verification
A fault in the pixel index or the state sequence shows at the ports within one pixel period. It appears as a write to the wrong address, a missing or repeated write, or a change in the spacing between writes. A divider that stops early or late changes both the stored grey value and the write spacing in average mode, so the fault is visible on the next write. A fault in the completion logic shows in the cycle after the final write, where dump_o and the rising edge of done_o must coincide.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_LATCH, ST_CALC, ST_DIV, ST_WRITE
  } gpe_state_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb8_t;
endpackage

// File: rtl/gpe_unpack.sv
module gpe_unpack
  import gpe_pkg::*;
(
  input  logic [15:0] pix_i,
  output rgb8_t       rgb_o
);
  // R2: 5-6-5 fields widened by zero fill on the right
  always_comb begin
    rgb_o.r = {pix_i[15:11], 3'b000};
    rgb_o.g = {pix_i[10:5],  2'b00};
    rgb_o.b = {pix_i[4:0],   3'b000};
  end
endmodule

// File: rtl/gpe_luma_w.sv
module gpe_luma_w
  import gpe_pkg::*;
(
  input  rgb8_t      rgb_i,
  output logic [7:0] y_o
);
  logic [9:0] rb_sum;
  always_comb begin
    rb_sum = 10'(rgb_i.r) + 10'(rgb_i.r) + 10'(rgb_i.r) + 10'(rgb_i.b);
    y_o    = 8'(rb_sum[9:3]) + 8'(rgb_i.g[7:1]);
  end
endmodule

// File: rtl/gpe_div_iter.sv
module gpe_div_iter #(
  parameter int IN_W    = 10,
  parameter int Q_W     = 8,
  parameter int DIVISOR = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [IN_W-1:0] dividend_i,
  output logic            fin_o,
  output logic [Q_W-1:0]  quot_o
);
  localparam logic [IN_W-1:0] DIV_V = IN_W'(DIVISOR);

  logic            busy_q, busy_d;
  logic [IN_W-1:0] rem_q, rem_d;
  logic [Q_W-1:0]  quo_q, quo_d;
  logic            under;

  // a difference below zero ends the loop; the remainder stays un-subtracted
  assign under  = rem_q < DIV_V;
  assign fin_o  = busy_q && under;
  assign quot_o = quo_q;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    if (load_i) begin
      busy_d = 1'b1;
      rem_d  = dividend_i;
      quo_d  = '0;
    end else if (busy_q) begin
      if (under) begin
        busy_d = 1'b0;
      end else begin
        rem_d = rem_q - DIV_V;
        quo_d = quo_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
    end
  end

  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (busy_q && quo_q == '0));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !under && !load_i) |=> (quo_q == $past(quo_q) + 1'b1));
endmodule

// File: rtl/gray_pixel_engine.sv
module gray_pixel_engine
  import gpe_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PIX_W     = 16,
  parameter int SRC_BASE  = 'h200,
  parameter int DST_BASE  = 'h584,
  parameter int PIX_COUNT = 900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              avg_mode_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [PIX_W-1:0]  mem_rdata_i,
  output logic [PIX_W-1:0]  mem_wdata_o,
  output logic              mem_we_o,
  output logic              done_o,
  output logic              dump_o
);
  localparam int CNT_W = (PIX_COUNT > 1) ? $clog2(PIX_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PIX_COUNT - 1);
  localparam logic [ADDR_W-1:0] SRC_A = ADDR_W'(SRC_BASE);
  localparam logic [ADDR_W-1:0] DST_A = ADDR_W'(DST_BASE);

  gpe_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [15:0]      pix_q, pix_d;
  logic [7:0]       y_q, y_d;
  logic             mode_q, mode_d;
  logic             done_q, done_d;
  logic             dump_q, dump_d;
  logic             div_load, div_fin;
  logic [7:0]       y_w, y_a;
  logic [9:0]       ch_sum;
  rgb8_t            rgb;

  gpe_unpack u_unpack (.pix_i(pix_q), .rgb_o(rgb));
  gpe_luma_w u_luma   (.rgb_i(rgb), .y_o(y_w));

  assign ch_sum = 10'(rgb.r) + 10'(rgb.g) + 10'(rgb.b);

  gpe_div_iter #(.IN_W(10), .Q_W(8), .DIVISOR(3)) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(div_load), .dividend_i(ch_sum),
    .fin_o(div_fin), .quot_o(y_a)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    pix_d    = pix_q;
    y_d      = y_q;
    mode_d   = mode_q;
    done_d   = done_q;
    dump_d   = 1'b0;
    div_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_READ;
        idx_d   = '0;
        mode_d  = avg_mode_i;
        done_d  = 1'b0;
      end
      ST_READ:  state_d = ST_LATCH;
      ST_LATCH: begin
        pix_d   = mem_rdata_i;
        state_d = ST_CALC;
      end
      ST_CALC: begin
        if (mode_q) begin
          div_load = 1'b1;
          state_d  = ST_DIV;
        end else begin
          y_d     = y_w;
          state_d = ST_WRITE;
        end
      end
      ST_DIV: if (div_fin) begin
        y_d     = y_a;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          dump_d  = 1'b1;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_READ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pix_q   <= '0;
      y_q     <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      dump_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pix_q   <= pix_d;
      y_q     <= y_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      dump_q  <= dump_d;
    end
  end

  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = mem_we_o ? (DST_A + ADDR_W'(idx_q)) : (SRC_A + ADDR_W'(idx_q));
  assign mem_wdata_o = {y_q[7:3], y_q[7:2], y_q[7:3]};
  assign done_o      = done_q;
  assign dump_o      = dump_q;

  p_dump_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dump_o |=> !dump_o);
  p_done_rise_dump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> dump_o);
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  p_we_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o >= DST_A && mem_addr_o < DST_A + ADDR_W'(PIX_COUNT)));
  p_busy_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !done_o);
endmodule

// File: tb/gray_pixel_engine_tb_top.sv
module gray_pixel_engine_tb_top;
  localparam int N   = 6;
  localparam int SRC = 'h010;
  localparam int DST = 'h040;

  // stimulus pixel, expected weighted Y, expected average Y
  localparam logic [15:0] VEC_PIX [N] = '{16'hFFFF, 16'h0000, 16'hF800, 16'h07E0, 16'h001F, 16'h1234};
  localparam logic [7:0]  VEC_YW  [N] = '{8'd250, 8'd0, 8'd93, 8'd126, 8'd31, 8'd60};
  localparam logic [7:0]  VEC_YA  [N] = '{8'd249, 8'd0, 8'd82, 8'd84, 8'd82, 8'd81};

  logic clk, rst_n, start_i, avg_mode_i, mem_we_o, done_o, dump_o;
  logic [11:0] mem_addr_o;
  logic [15:0] mem_rdata_i, mem_wdata_o;
  logic [15:0] mem [4096];

  int checks = 0, errors = 0, cyc = 0;
  int wr_n = 0, dump_n = 0, dump_cyc = 0, dump_done_ok = 0;
  int wr_cyc [16];
  logic [11:0] wr_addr [16];

  gray_pixel_engine #(.SRC_BASE(SRC), .DST_BASE(DST), .PIX_COUNT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .avg_mode_i(avg_mode_i),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .done_o(done_o), .dump_o(dump_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o) begin
      mem[mem_addr_o] <= mem_wdata_o;
      if (wr_n < 16) begin
        wr_cyc[wr_n]  <= cyc;
        wr_addr[wr_n] <= mem_addr_o;
      end
      wr_n <= wr_n + 1;
    end
    if (dump_o) begin
      dump_n   <= dump_n + 1;
      dump_cyc <= cyc;
      dump_done_ok <= done_o ? 1 : 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pack_grey(input logic [7:0] y);
    return {y[7:3], y[7:2], y[7:3]};
  endfunction

  function automatic int ch_sum(input logic [15:0] p);
    return int'({p[15:11], 3'b0}) + int'({p[10:5], 2'b0}) + int'({p[4:0], 3'b0});
  endfunction

  task automatic prep();
    for (int i = 0; i < N; i++) mem[SRC+i] = VEC_PIX[i];
    for (int i = -1; i <= N; i++) mem[DST+i] = 16'hDEAD;
    wr_n = 0; dump_n = 0;
  endtask

  task automatic pulse_start(input logic mode);
    @(negedge clk); start_i = 1'b1; avg_mode_i = mode;
    @(negedge clk); start_i = 1'b0; avg_mode_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 5000 && !done_o; t++) @(negedge clk);
    chk("R9 done reached", done_o, 1'b1);
  endtask

  task automatic check_run(input logic mode);
    chk("R6 write count", wr_n, N);
    for (int i = 0; i < N && i < wr_n; i++) begin
      chk("R6 write order", wr_addr[i], 12'(DST + i));
      chk(mode ? "R4 R5 avg word" : "R3 R5 weighted word", mem[DST+i],
          pack_grey(mode ? VEC_YA[i] : VEC_YW[i]));
      if (i > 0)
        chk(mode ? "R8 avg spacing" : "R7 weighted spacing", wr_cyc[i] - wr_cyc[i-1],
            mode ? 5 + ch_sum(VEC_PIX[i]) / 3 : 4);
    end
    chk("R6 below region untouched", mem[DST-1], 16'hDEAD);
    chk("R6 above region untouched", mem[DST+N], 16'hDEAD);
    chk("R9 single dump", dump_n, 1);
    chk("R9 dump after last write", dump_cyc, wr_cyc[N-1] + 1);
    chk("R9 done with dump", dump_done_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    rst_n = 1'b0; start_i = 1'b0; avg_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done_o, 1'b0);
    chk("R1 dump in reset", dump_o, 1'b0);
    chk("R1 we in reset", mem_we_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done_o, 1'b0);
    chk("R1 we after reset", mem_we_o, 1'b0);

    // R2 R3 R5 R7: weighted pass over the vector table
    prep();
    pulse_start(1'b0);
    wait_done();
    @(negedge clk);
    check_run(1'b0);

    // R9: done held, nothing further written
    repeat (20) @(negedge clk);
    chk("R9 done held", done_o, 1'b1);
    chk("R9 no extra writes", wr_n, N);

    // R4 R8 R10: average pass with stray starts mid-run
    prep();
    pulse_start(1'b1);
    chk("R9 done cleared by start", done_o, 1'b0);
    repeat (8) @(negedge clk);
    pulse_start(1'b0);
    repeat (300) @(negedge clk);
    pulse_start(1'b0);
    wait_done();
    @(negedge clk);
    check_run(1'b1);
    chk("R10 stray start ignored", dump_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule